// File: doc/BRIEF.md
# Fully Associative Translation Buffer

The block holds a small set of page-table entries and translates virtual page numbers to physical frame numbers in the same cycle that a lookup is presented. Every entry stores a virtual page tag, an address space number, a global flag, a physical frame number, a read-enable mask and a write-enable mask with one bit per privilege mode, and two fault flags that make a read or a write trap even when the mask allows it. A lookup returns a hit flag, the index of the matching slot and all stored fields of that slot. The caller performs the permission checks on those fields.

New entries are written through an insert port into the slot named by a round-robin pointer. The slot's previous contents are overwritten. Three flush commands remove entries. The first invalidates every slot and rewinds the pointer. The second invalidates all entries not marked global, which is used on an address-space switch. The third invalidates the entries that would hit for a given page and address space. Pages are 8 KB, so the page number is the virtual address from bit 13 upward. Typical sizes are 48 slots for instruction fetch and 64 for data.

Top module: `assoc_tlb`

## Requirements
- R1: A slot hits only when it is valid, its tag equals the lookup page number, and either its global flag is set or its stored address space number equals `lk_asn_i`.
- R2: The page number is `VA[VA_W-1:PAGE_BITS]`. The low `PAGE_BITS` address bits have no effect on the lookup or on the flush-by-address command.
- R3: When several slots hit, the lowest index is reported. On a miss, `lk_idx_o` and every field output are zero. The hit, index and fields are combinational from the lookup inputs.
- R4: An insert (`ins_valid_i`=1 with no flush command) writes slot `nxt_idx_o`, replaces its previous contents, sets it valid, and advances `nxt_idx_o` by one at the same clock edge.
- R5: `nxt_idx_o` wraps from `ENTRIES-1` to 0.
- R6: A flush command of code 1 (flush-all) invalidates every slot and sets `nxt_idx_o` to 0.
- R7: A flush command of code 2 (flush-process) invalidates every non-global slot, keeps the global slots, and leaves `nxt_idx_o` unchanged.
- R8: A flush command of code 3 (flush-address) invalidates every slot that would hit under the R1 rule for `fl_va_i`/`fl_asn_i`, and leaves all other slots and `nxt_idx_o` unchanged.
- R9: A lookup made in the same cycle as a flush sees the contents from before the flush. The flush takes effect at the next clock edge.
- R10: While `fl_cmd_i` is non-zero, `ins_valid_i` is ignored. No slot is written and the pointer moves only as the flush dictates.
- R11: After reset, every slot is invalid and `nxt_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_va_i | input | VA_W | Lookup virtual address |
| lk_asn_i | input | ASN_W | Current address space number |
| lk_hit_o | output | 1 | Lookup hit |
| lk_idx_o | output | IDX_W | Index of the hitting slot |
| lk_pfn_o | output | PFN_W | Physical frame number of the hit |
| lk_rd_en_o | output | MODES | Per-mode read enables of the hit |
| lk_wr_en_o | output | MODES | Per-mode write enables of the hit |
| lk_fault_rd_o | output | 1 | Fault-on-read flag of the hit |
| lk_fault_wr_o | output | 1 | Fault-on-write flag of the hit |
| lk_global_o | output | 1 | Global flag of the hit |
| ins_valid_i | input | 1 | Insert request |
| ins_va_i | input | VA_W | Virtual address of the new entry |
| ins_asn_i | input | ASN_W | Address space number of the new entry |
| ins_global_i | input | 1 | Global flag of the new entry |
| ins_pfn_i | input | PFN_W | Frame number of the new entry |
| ins_rd_en_i | input | MODES | Read enables of the new entry |
| ins_wr_en_i | input | MODES | Write enables of the new entry |
| ins_fault_rd_i | input | 1 | Fault-on-read flag of the new entry |
| ins_fault_wr_i | input | 1 | Fault-on-write flag of the new entry |
| fl_cmd_i | input | 2 | Flush command: 0 none, 1 all, 2 process, 3 address |
| fl_va_i | input | VA_W | Flush-by-address virtual address |
| fl_asn_i | input | ASN_W | Flush-by-address space number |
| nxt_idx_o | output | IDX_W | Next slot to be written by an insert |

## Verification
The bench drives a four-slot instance and sweeps every page number against every address space number after each operation, with page-offset bits varied. The sweep would catch a design that ignored the global flag, compared the offset bits, or did not settle overlapping hits toward the lowest index. It fills the buffer past its end, so an off-by-one pointer or a missing wrap shows up as the wrong slot being evicted. Flush-process and flush-address are run against a mix of global and private entries with the same page number, so a flush that also removed global entries, or that ignored the address space, leaves the wrong survivors. It also presents a lookup during a flush cycle and an insert during a flush. A design whose flush acted combinationally, or that let the insert through, would report a hit or pointer value that differs from the expected one.

// File: rtl/assoc_tlb_pkg.sv
package assoc_tlb_pkg;
  typedef enum logic [1:0] {
    FL_NONE = 2'd0,
    FL_ALL  = 2'd1,
    FL_PROC = 2'd2,
    FL_ADDR = 2'd3
  } fl_cmd_e;
endpackage

// File: rtl/tlb_match_vec.sv
module tlb_match_vec #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 30,
  parameter int ASN_W   = 8
) (
  input  logic [ENTRIES-1:0]            valid_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tag_i,
  input  logic [ENTRIES-1:0][ASN_W-1:0] asn_i,
  input  logic [ENTRIES-1:0]            glb_i,
  input  logic [VPN_W-1:0]              vpn_i,
  input  logic [ASN_W-1:0]              cur_asn_i,
  output logic [ENTRIES-1:0]            hit_vec_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec_o[g] = valid_i[g] && (tag_i[g] == vpn_i)
                          && (glb_i[g] || (asn_i[g] == cur_asn_i));
  end
endmodule

// File: rtl/tlb_first_one.sv
module tlb_first_one #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] req_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);
  // scan downward so the lowest set bit is assigned last
  always_comb begin
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign found_o = |req_i;
endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (clr_i)  ptr_o <= '0;
    else if (adv_i)  ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 30,
  parameter int ASN_W   = 8,
  parameter int PFN_W   = 27,
  parameter int MODES   = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic [IDX_W-1:0]              wr_idx_i,
  input  logic [VPN_W-1:0]              wr_tag_i,
  input  logic [ASN_W-1:0]              wr_asn_i,
  input  logic                          wr_glb_i,
  input  logic [PFN_W-1:0]              wr_pfn_i,
  input  logic [MODES-1:0]              wr_rden_i,
  input  logic [MODES-1:0]              wr_wren_i,
  input  logic                          wr_frd_i,
  input  logic                          wr_fwr_i,
  input  logic [ENTRIES-1:0]            kill_i,
  output logic [ENTRIES-1:0]            vld_o,
  output logic [ENTRIES-1:0][VPN_W-1:0] tag_o,
  output logic [ENTRIES-1:0][ASN_W-1:0] asn_o,
  output logic [ENTRIES-1:0]            glb_o,
  output logic [ENTRIES-1:0][PFN_W-1:0] pfn_o,
  output logic [ENTRIES-1:0][MODES-1:0] rden_o,
  output logic [ENTRIES-1:0][MODES-1:0] wren_o,
  output logic [ENTRIES-1:0]            frd_o,
  output logic [ENTRIES-1:0]            fwr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= '0;
    end else begin
      vld_o <= vld_o & ~kill_i;
      if (wr_i) vld_o[wr_idx_i] <= 1'b1;
    end
  end

  // payload needs no reset: qualified by vld_o
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (wr_i && (wr_idx_i == IDX_W'(g))) begin
        tag_o[g]  <= wr_tag_i;
        asn_o[g]  <= wr_asn_i;
        glb_o[g]  <= wr_glb_i;
        pfn_o[g]  <= wr_pfn_i;
        rden_o[g] <= wr_rden_i;
        wren_o[g] <= wr_wren_i;
        frd_o[g]  <= wr_frd_i;
        fwr_o[g]  <= wr_fwr_i;
      end
    end
  end
endmodule

// File: rtl/assoc_tlb.sv
module assoc_tlb
  import assoc_tlb_pkg::*;
#(
  parameter int ENTRIES   = 64,
  parameter int VA_W      = 43,
  parameter int PAGE_BITS = 13,
  parameter int ASN_W     = 8,
  parameter int PFN_W     = 27,
  parameter int MODES     = 4,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VA_W-1:0]  lk_va_i,
  input  logic [ASN_W-1:0] lk_asn_i,
  output logic             lk_hit_o,
  output logic [IDX_W-1:0] lk_idx_o,
  output logic [PFN_W-1:0] lk_pfn_o,
  output logic [MODES-1:0] lk_rd_en_o,
  output logic [MODES-1:0] lk_wr_en_o,
  output logic             lk_fault_rd_o,
  output logic             lk_fault_wr_o,
  output logic             lk_global_o,
  input  logic             ins_valid_i,
  input  logic [VA_W-1:0]  ins_va_i,
  input  logic [ASN_W-1:0] ins_asn_i,
  input  logic             ins_global_i,
  input  logic [PFN_W-1:0] ins_pfn_i,
  input  logic [MODES-1:0] ins_rd_en_i,
  input  logic [MODES-1:0] ins_wr_en_i,
  input  logic             ins_fault_rd_i,
  input  logic             ins_fault_wr_i,
  input  logic [1:0]       fl_cmd_i,
  input  logic [VA_W-1:0]  fl_va_i,
  input  logic [ASN_W-1:0] fl_asn_i,
  output logic [IDX_W-1:0] nxt_idx_o
);
  fl_cmd_e cmd;
  assign cmd = fl_cmd_e'(fl_cmd_i);

  logic [ENTRIES-1:0]            vld, glb, frd, fwr;
  logic [ENTRIES-1:0][VPN_W-1:0] tag;
  logic [ENTRIES-1:0][ASN_W-1:0] asn;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn;
  logic [ENTRIES-1:0][MODES-1:0] rden, wren;
  logic [ENTRIES-1:0]            lk_hit_vec, fl_hit_vec, kill;
  logic                          do_ins, lk_found;
  logic [IDX_W-1:0]              lk_sel;

  assign do_ins = ins_valid_i && (cmd == FL_NONE);

  always_comb begin
    unique case (cmd)
      FL_ALL:  kill = '1;
      FL_PROC: kill = ~glb;
      FL_ADDR: kill = fl_hit_vec;
      default: kill = '0;
    endcase
  end

  tlb_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W), .PFN_W(PFN_W), .MODES(MODES)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (do_ins),
    .wr_idx_i  (nxt_idx_o),
    .wr_tag_i  (ins_va_i[VA_W-1:PAGE_BITS]),
    .wr_asn_i  (ins_asn_i),
    .wr_glb_i  (ins_global_i),
    .wr_pfn_i  (ins_pfn_i),
    .wr_rden_i (ins_rd_en_i),
    .wr_wren_i (ins_wr_en_i),
    .wr_frd_i  (ins_fault_rd_i),
    .wr_fwr_i  (ins_fault_wr_i),
    .kill_i    (kill),
    .vld_o     (vld),
    .tag_o     (tag),
    .asn_o     (asn),
    .glb_o     (glb),
    .pfn_o     (pfn),
    .rden_o    (rden),
    .wren_o    (wren),
    .frd_o     (frd),
    .fwr_o     (fwr)
  );

  tlb_match_vec #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk_match (
    .valid_i   (vld),
    .tag_i     (tag),
    .asn_i     (asn),
    .glb_i     (glb),
    .vpn_i     (lk_va_i[VA_W-1:PAGE_BITS]),
    .cur_asn_i (lk_asn_i),
    .hit_vec_o (lk_hit_vec)
  );

  tlb_match_vec #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_fl_match (
    .valid_i   (vld),
    .tag_i     (tag),
    .asn_i     (asn),
    .glb_i     (glb),
    .vpn_i     (fl_va_i[VA_W-1:PAGE_BITS]),
    .cur_asn_i (fl_asn_i),
    .hit_vec_o (fl_hit_vec)
  );

  tlb_first_one #(.ENTRIES(ENTRIES)) u_pick (
    .req_i   (lk_hit_vec),
    .found_o (lk_found),
    .idx_o   (lk_sel)
  );

  tlb_rr_ptr #(.ENTRIES(ENTRIES)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cmd == FL_ALL),
    .adv_i  (do_ins),
    .ptr_o  (nxt_idx_o)
  );

  assign lk_hit_o      = lk_found;
  assign lk_idx_o      = lk_found ? lk_sel       : '0;
  assign lk_pfn_o      = lk_found ? pfn[lk_sel]  : '0;
  assign lk_rd_en_o    = lk_found ? rden[lk_sel] : '0;
  assign lk_wr_en_o    = lk_found ? wren[lk_sel] : '0;
  assign lk_fault_rd_o = lk_found && frd[lk_sel];
  assign lk_fault_wr_o = lk_found && fwr[lk_sel];
  assign lk_global_o   = lk_found && glb[lk_sel];
endmodule

// File: rtl/assoc_tlb_chk.sv
module assoc_tlb_chk #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 6,
  parameter int PFN_W   = 27
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         fl_cmd_i,
  input logic               ins_valid_i,
  input logic [IDX_W-1:0]   nxt_idx_o,
  input logic               lk_hit_o,
  input logic [IDX_W-1:0]   lk_idx_o,
  input logic [PFN_W-1:0]   lk_pfn_o,
  input logic [ENTRIES-1:0] vld_i,
  input logic [ENTRIES-1:0] glb_i,
  input logic [ENTRIES-1:0] fl_hit_i
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && fl_cmd_i == 2'd0) |=>
      nxt_idx_o == (($past(nxt_idx_o) == LAST) ? '0 : $past(nxt_idx_o) + 1'b1)); // R4 R5

  AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_cmd_i == 2'd1) |=> (vld_i == '0 && nxt_idx_o == '0)); // R6

  AST_FLUSH_PROC_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_cmd_i == 2'd2) |=> vld_i == ($past(vld_i) & $past(glb_i))); // R7

  AST_FLUSH_ADDR_GONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_cmd_i == 2'd3) |=> ((vld_i & $past(fl_hit_i)) == '0)); // R8

  AST_FLUSH_BLOCKS_INS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_cmd_i == 2'd2 || fl_cmd_i == 2'd3) |=> $stable(nxt_idx_o)); // R10

  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (lk_idx_o == '0 && lk_pfn_o == '0)); // R3
endmodule

bind assoc_tlb assoc_tlb_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .PFN_W(PFN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fl_cmd_i    (fl_cmd_i),
  .ins_valid_i (ins_valid_i),
  .nxt_idx_o   (nxt_idx_o),
  .lk_hit_o    (lk_hit_o),
  .lk_idx_o    (lk_idx_o),
  .lk_pfn_o    (lk_pfn_o),
  .vld_i       (vld),
  .glb_i       (glb),
  .fl_hit_i    (fl_hit_vec)
);

// File: tb/assoc_tlb_tb.sv
module assoc_tlb_tb;
  localparam int CLK_P = 100;
  localparam int E  = 4;
  localparam int VA = 16;
  localparam int PB = 13;
  localparam int AW = 2;
  localparam int PW = 4;
  localparam int MD = 4;
  localparam int VW = VA - PB;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  logic [VA-1:0] lk_va = '0, ins_va = '0, fl_va = '0;
  logic [AW-1:0] lk_asn = '0, ins_asn = '0, fl_asn = '0;
  logic          ins_valid = 1'b0, ins_glb = 1'b0, ins_frd = 1'b0, ins_fwr = 1'b0;
  logic [PW-1:0] ins_pfn = '0;
  logic [MD-1:0] ins_rd = '0, ins_wr = '0;
  logic [1:0]    fl_cmd = '0;
  logic          hit, f_rd, f_wr, glb_o;
  logic [IW-1:0] idx, nxt;
  logic [PW-1:0] pfn;
  logic [MD-1:0] rd_en, wr_en;

  assoc_tlb #(.ENTRIES(E), .VA_W(VA), .PAGE_BITS(PB), .ASN_W(AW), .PFN_W(PW), .MODES(MD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_va_i(lk_va), .lk_asn_i(lk_asn), .lk_hit_o(hit), .lk_idx_o(idx), .lk_pfn_o(pfn),
    .lk_rd_en_o(rd_en), .lk_wr_en_o(wr_en), .lk_fault_rd_o(f_rd), .lk_fault_wr_o(f_wr),
    .lk_global_o(glb_o),
    .ins_valid_i(ins_valid), .ins_va_i(ins_va), .ins_asn_i(ins_asn), .ins_global_i(ins_glb),
    .ins_pfn_i(ins_pfn), .ins_rd_en_i(ins_rd), .ins_wr_en_i(ins_wr),
    .ins_fault_rd_i(ins_frd), .ins_fault_wr_i(ins_fwr),
    .fl_cmd_i(fl_cmd), .fl_va_i(fl_va), .fl_asn_i(fl_asn), .nxt_idx_o(nxt)
  );

  // reference model
  bit          m_v[E];
  bit          m_g[E];
  int unsigned m_tag[E], m_asn[E], m_pfn[E];
  int unsigned m_ptr;
  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_match(int i, int unsigned vpn, int unsigned a);
    return m_v[i] && m_tag[i] == vpn && (m_g[i] || m_asn[i] == a);
  endfunction

  // fields derived from pfn so each slot is distinct
  function automatic logic [MD+MD+3-1:0] m_flds(int unsigned p, bit g);
    logic [PW-1:0] pp = PW'(p);
    return {~pp, pp + 4'd3, pp[0], pp[1], g};
  endfunction

  task automatic lookup_chk(input int unsigned vpn, input int unsigned a, input string req);
    int e = -1;
    lk_va  = {VW'(vpn), PB'((vpn * 997 + a * 1231) & 13'h1fff)};
    lk_asn = AW'(a);
    #1;
    for (int i = E - 1; i >= 0; i--) if (m_match(i, vpn, a)) e = i;
    if (e < 0)
      chk(!hit && idx == 0 && pfn == 0 && rd_en == 0 && wr_en == 0 && !f_rd && !f_wr && !glb_o,
          {req, " miss"}, {hit, idx, pfn}, 0);
    else
      chk(hit && idx == IW'(e) && pfn == PW'(m_pfn[e])
          && {rd_en, wr_en, f_rd, f_wr, glb_o} == m_flds(m_pfn[e], m_g[e]),
          {req, " hit"}, {hit, idx, pfn}, {1'b1, IW'(e), PW'(m_pfn[e])});
  endtask

  task automatic sweep(input string req);
    for (int v = 0; v < (1 << VW); v++)
      for (int a = 0; a < (1 << AW); a++) lookup_chk(v, a, req);
    chk(nxt == IW'(m_ptr), {req, " R4 R5 pointer"}, nxt, m_ptr);
  endtask

  task automatic do_ins(input int unsigned vpn, input int unsigned a, input bit g, input int unsigned p);
    logic [MD+MD+3-1:0] f = m_flds(p, g);
    @(negedge clk);
    ins_valid = 1'b1;
    ins_va  = {VW'(vpn), PB'(vpn * 71 + 5)};
    ins_asn = AW'(a); ins_glb = g; ins_pfn = PW'(p);
    {ins_rd, ins_wr, ins_frd, ins_fwr} = f[MD+MD+3-1:1];
    @(negedge clk);
    ins_valid = 1'b0;
    m_v[m_ptr] = 1; m_tag[m_ptr] = vpn; m_asn[m_ptr] = a; m_g[m_ptr] = g; m_pfn[m_ptr] = p;
    m_ptr = (m_ptr + 1) % E;
  endtask

  task automatic do_flush(input logic [1:0] c, input int unsigned vpn, input int unsigned a);
    @(negedge clk);
    fl_cmd = c; fl_va = {VW'(vpn), PB'(13'h0abc)}; fl_asn = AW'(a);
    @(negedge clk);
    fl_cmd = 2'd0;
    for (int i = 0; i < E; i++) begin
      if (c == 2'd1) m_v[i] = 0;
      if (c == 2'd2 && !m_g[i]) m_v[i] = 0;
      if (c == 2'd3 && m_match(i, vpn, a)) m_v[i] = 0;
    end
    if (c == 2'd1) m_ptr = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    m_ptr = 0;
    for (int i = 0; i < E; i++) begin m_v[i] = 0; m_g[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    sweep("R11 reset");

    // fill and wrap; same page under different spaces
    do_ins(1, 1, 0, 3);  sweep("R1 R2 insert");
    do_ins(2, 0, 1, 5);  sweep("R1 global");
    do_ins(1, 2, 0, 7);  sweep("R1 asn qualify");
    do_ins(5, 3, 0, 11); sweep("R5 wrap");
    do_ins(1, 1, 0, 9);  sweep("R4 evict slot0");
    do_ins(1, 0, 1, 13); sweep("R3 lowest index");

    // R7: slot1 global survives
    do_flush(2'd2, 0, 0); sweep("R7 flush process");

    do_ins(3, 1, 0, 2); do_ins(3, 2, 1, 4); do_ins(6, 1, 0, 6);
    sweep("R4 refill");
    // R8: wrong-asn private page kept, global page removed by any asn
    do_flush(2'd3, 6, 2); sweep("R8 addr asn mismatch");
    do_flush(2'd3, 3, 0); sweep("R8 addr global");
    do_flush(2'd3, 6, 1); sweep("R8 addr private");

    // R9: lookup during flush-all sees old contents
    do_ins(4, 2, 0, 8);
    @(negedge clk);
    fl_cmd = 2'd1;
    lookup_chk(4, 2, "R9 same cycle");
    @(negedge clk);
    fl_cmd = 2'd0;
    for (int i = 0; i < E; i++) m_v[i] = 0;
    m_ptr = 0;
    sweep("R6 flush all");

    // R10: insert during flush is dropped
    do_ins(7, 3, 0, 1);
    @(negedge clk);
    fl_cmd = 2'd3; fl_va = '0; fl_asn = '0;
    ins_valid = 1'b1; ins_va = {VW'(2), PB'(0)}; ins_asn = 2'd1; ins_glb = 1'b0; ins_pfn = 4'd12;
    @(negedge clk);
    fl_cmd = 2'd0; ins_valid = 1'b0;
    sweep("R10 insert blocked");
    @(negedge clk);
    fl_cmd = 2'd2; ins_valid = 1'b1;
    @(negedge clk);
    fl_cmd = 2'd0; ins_valid = 1'b0;
    for (int i = 0; i < E; i++) if (!m_g[i]) m_v[i] = 0;
    sweep("R10 R7 insert blocked");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule